// File: doc/BRIEF.md
# Slave Interrupt and Attention Controller

This block keeps the interrupt state of a disk-style peripheral slave that can be reached from several host ports. It tracks three interrupt classes (pending status exception, rotational position on target, time-dependent command completion), a per-port notice that another port has forced a priority selection, and a per-port latch that records the slave leaving its busy state. From these it assembles, for each port, the eight-bit interrupt octet that the host reads when it polls the slave.

The same state drives one attention line per port. A port's attention is raised only while that port has not selected the slave. Each port masks the four attention sources with its own enable bits, which the host writes. Command decoding, the disk mechanism and the bus sequencing that produce the event pulses are outside the block. All event inputs are single-cycle strobes, and the flags change on the clock edge that samples them.

Top module: `slave_attn_ctrl`

## Requirements
- R1: `statusPend` (octet bit 2) becomes 1 the cycle after an `excSet` pulse. It returns to 0 the cycle after `statusReadDone` is sampled with `masterOk` high. `excSet` wins when both occur in the same cycle.
- R2: A `statusReadDone` with `masterOk` low leaves `statusPend` unchanged.
- R3: A `slaveReset` pulse clears all three class flags, the priority notices and the no-longer-busy latches, and disables the position target. It also restores every port's enables to their reset value 4'b0111, which is the same value `rstN` gives them.
- R4: While a target is enabled, `rpsInt` (octet bit 1) rises the cycle after `rpsOnTarget` rises. It falls the cycle after `rpsOnTarget` is low. Loading target value 16'hFFFF disables the target, and no interrupt arises until a different value is loaded. After reset the target is disabled.
- R5: A `dataCtlAccept` pulse drops `rpsInt` even while `rpsOnTarget` stays high. The interrupt does not return until the next rising edge of `rpsOnTarget`.
- R6: `cmdCmpl` (octet bit 0) is set by `cmdDone` with `cmdTimeDep` high. It is not set when `cmdIsLoadPos` is high while a target is enabled. Any `busCtlAccept` clears it, and a same-cycle `cmdDone` wins over that clear.
- R7: Port p's octet is `intOctet[8p+7:8p]` = {0, busy, ready, 0, priority notice, statusPend, rpsInt, cmdCmpl}, from bit 7 down to bit 0.
- R8: A `prioSeen[p]` pulse sets port p's notice (bit 3) on that port only. A `seqEnd[p]` clears the notice only if `reportReq[p]` was seen while the notice was set, within that sequence.
- R9: `attn[p]` is 0 while `selected[p]` is high. Otherwise it is the OR of the sources masked by port p's enables: bit 0 RPS, bit 1 command completion, bit 2 status pending, bit 3 no-longer-busy.
- R10: A falling edge of `busy` sets every port's no-longer-busy latch one cycle later. `selAttempt[p]` clears port p's latch. The no-longer-busy enable is off after reset.
- R11: An `enWr[p]` pulse loads `enData` into port p's enables only, with effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slaveReset | input | 1 | Selective reset with the slave-reset bit set |
| excSet | input | 1 | A status exception has occurred |
| statusReadDone | input | 1 | A status read transfer has ended |
| masterOk | input | 1 | Master status reported a successful transfer |
| rpsTargetLoad | input | 1 | Load a new position target |
| rpsTargetVal | input | TGT_W | Target value; all ones disables |
| rpsOnTarget | input | 1 | Heads are over the target sector |
| busCtlAccept | input | 1 | Any bus control was accepted |
| dataCtlAccept | input | 1 | A data control was accepted |
| cmdDone | input | 1 | A command completed successfully |
| cmdTimeDep | input | 1 | That command was accepted as time-dependent |
| cmdIsLoadPos | input | 1 | That command was a load-position command |
| busy | input | 1 | The slave is busy |
| ready | input | 1 | The slave is operational |
| prioSeen | input | PORTS | Another port forced a priority selection |
| reportReq | input | PORTS | The interrupt octet was requested on the port |
| seqEnd | input | PORTS | The bus sequence on the port has ended |
| selected | input | PORTS | The port currently has the slave selected |
| selAttempt | input | PORTS | A selection was attempted on the port |
| enWr | input | PORTS | Write the port's attention enables |
| enData | input | 4 | Enable value to write |
| intOctet | output | 8*PORTS | Interrupt octet per port |
| attn | output | PORTS | Attention per port |
| statusPend | output | 1 | Status-pending class flag |
| rpsInt | output | 1 | Position interrupt class flag |
| cmdCmpl | output | 1 | Command-completion class flag |

## Verification
The properties assume that every event input is a single-cycle strobe. They also assume that `dataCtlAccept` only occurs together with `busCtlAccept`, and that a status read, a bus-control acceptance and a slave reset come as separate events unless a test combines them on purpose. The stimulus drives each event for exactly one cycle at the falling clock edge. It asserts the data-control strobe only with the bus-control strobe, and it keeps the selection and busy inputs steady across the cycles in which flags are observed. The clear properties exclude a same-cycle set, because the block lets the set win.

// File: rtl/slvint_pkg.sv
package slvint_pkg;

  localparam int EN_W = 4;
  localparam int EN_RPS = 0;
  localparam int EN_CMD = 1;
  localparam int EN_STAT = 2;
  localparam int EN_NB = 3;
  localparam logic [EN_W-1:0] EN_RESET = 4'b0111;

  localparam int OCT_CMD = 0;
  localparam int OCT_RPS = 1;
  localparam int OCT_STAT = 2;
  localparam int OCT_PRIO = 3;
  localparam int OCT_READY = 5;
  localparam int OCT_BUSY = 6;

  typedef struct packed {
    logic slvRst;
    logic setStatus;
    logic clrStatus;
    logic setRps;
    logic clrRps;
    logic rpsEnLoad;
    logic rpsEnVal;
    logic setCmd;
    logic clrCmd;
    logic busyFell;
  } slvStrobe_t;

endpackage

// File: rtl/slvint_ctrl.sv
module slvint_ctrl
  import slvint_pkg::*;
#(
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slaveReset,
  input  logic             excSet,
  input  logic             statusReadDone,
  input  logic             masterOk,
  input  logic             rpsTargetLoad,
  input  logic [TGT_W-1:0] rpsTargetVal,
  input  logic             rpsOnTarget,
  input  logic             dataCtlAccept,
  input  logic             busCtlAccept,
  input  logic             cmdDone,
  input  logic             cmdTimeDep,
  input  logic             cmdIsLoadPos,
  input  logic             busy,
  input  logic             rpsEn,
  output slvStrobe_t       stb
);

  localparam logic [TGT_W-1:0] TGT_OFF = '1;

  logic onTargetQ;
  logic busyQ;
  logic targetOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onTargetQ <= 1'b0;
      busyQ     <= 1'b0;
    end else begin
      onTargetQ <= rpsOnTarget;
      busyQ     <= busy;
    end
  end

  assign targetOff = rpsTargetLoad && (rpsTargetVal == TGT_OFF);

  always_comb begin
    stb           = '0;
    stb.slvRst    = slaveReset;
    stb.setStatus = excSet;
    stb.clrStatus = statusReadDone && masterOk;
    stb.rpsEnLoad = rpsTargetLoad;
    stb.rpsEnVal  = !targetOff;
    stb.setRps    = rpsEn && rpsOnTarget && !onTargetQ;
    stb.clrRps    = !rpsOnTarget || dataCtlAccept || targetOff;
    stb.setCmd    = cmdDone && cmdTimeDep && !(cmdIsLoadPos && rpsEn);
    stb.clrCmd    = busCtlAccept;
    stb.busyFell  = busyQ && !busy;
  end

endmodule

// File: rtl/slvint_core.sv
module slvint_core
  import slvint_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  slvStrobe_t stb,
  output logic       statusPend,
  output logic       rpsInt,
  output logic       cmdCmpl,
  output logic       rpsEn
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusPend <= 1'b0;
      rpsInt     <= 1'b0;
      cmdCmpl    <= 1'b0;
      rpsEn      <= 1'b0;
    end else if (stb.slvRst) begin
      statusPend <= 1'b0;
      rpsInt     <= 1'b0;
      cmdCmpl    <= 1'b0;
      rpsEn      <= 1'b0;
    end else begin
      if (stb.setStatus)      statusPend <= 1'b1;
      else if (stb.clrStatus) statusPend <= 1'b0;

      if (stb.clrRps)         rpsInt <= 1'b0;
      else if (stb.setRps)    rpsInt <= 1'b1;

      if (stb.setCmd)         cmdCmpl <= 1'b1;
      else if (stb.clrCmd)    cmdCmpl <= 1'b0;

      if (stb.rpsEnLoad)      rpsEn <= stb.rpsEnVal;
    end
  end

endmodule

// File: rtl/slvint_port.sv
module slvint_port
  import slvint_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  slvStrobe_t      stb,
  input  logic            prioSeen,
  input  logic            reportReq,
  input  logic            seqEnd,
  input  logic            selected,
  input  logic            selAttempt,
  input  logic            enWr,
  input  logic [EN_W-1:0] enData,
  input  logic            busy,
  input  logic            ready,
  input  logic            statusPend,
  input  logic            rpsInt,
  input  logic            cmdCmpl,
  output logic [7:0]      octet,
  output logic            attn
);

  logic [EN_W-1:0] enables;
  logic            prioFlag;
  logic            prioShown;
  logic            notBusyFlag;
  logic            shownNow;
  logic [EN_W-1:0] sources;

  assign shownNow = prioShown || (reportReq && prioFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enables     <= EN_RESET;
      prioFlag    <= 1'b0;
      prioShown   <= 1'b0;
      notBusyFlag <= 1'b0;
    end else if (stb.slvRst) begin
      enables     <= EN_RESET;
      prioFlag    <= 1'b0;
      prioShown   <= 1'b0;
      notBusyFlag <= 1'b0;
    end else begin
      if (enWr) enables <= enData;

      if (prioSeen)                  prioFlag <= 1'b1;
      else if (seqEnd && shownNow)   prioFlag <= 1'b0;

      if (seqEnd)                    prioShown <= 1'b0;
      else if (reportReq && prioFlag) prioShown <= 1'b1;

      if (stb.busyFell)              notBusyFlag <= 1'b1;
      else if (selAttempt)           notBusyFlag <= 1'b0;
    end
  end

  always_comb begin
    octet            = '0;
    octet[OCT_BUSY]  = busy;
    octet[OCT_READY] = ready;
    octet[OCT_PRIO]  = prioFlag;
    octet[OCT_STAT]  = statusPend;
    octet[OCT_RPS]   = rpsInt;
    octet[OCT_CMD]   = cmdCmpl;
  end

  always_comb begin
    sources          = '0;
    sources[EN_RPS]  = rpsInt;
    sources[EN_CMD]  = cmdCmpl;
    sources[EN_STAT] = statusPend;
    sources[EN_NB]   = notBusyFlag;
    attn = !selected && |(sources & enables);
  end

endmodule

// File: rtl/slave_attn_ctrl.sv
module slave_attn_ctrl
  import slvint_pkg::*;
#(
  parameter int PORTS = 2,
  parameter int TGT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slaveReset,
  input  logic               excSet,
  input  logic               statusReadDone,
  input  logic               masterOk,
  input  logic               rpsTargetLoad,
  input  logic [TGT_W-1:0]   rpsTargetVal,
  input  logic               rpsOnTarget,
  input  logic               busCtlAccept,
  input  logic               dataCtlAccept,
  input  logic               cmdDone,
  input  logic               cmdTimeDep,
  input  logic               cmdIsLoadPos,
  input  logic               busy,
  input  logic               ready,
  input  logic [PORTS-1:0]   prioSeen,
  input  logic [PORTS-1:0]   reportReq,
  input  logic [PORTS-1:0]   seqEnd,
  input  logic [PORTS-1:0]   selected,
  input  logic [PORTS-1:0]   selAttempt,
  input  logic [PORTS-1:0]   enWr,
  input  logic [EN_W-1:0]    enData,
  output logic [8*PORTS-1:0] intOctet,
  output logic [PORTS-1:0]   attn,
  output logic               statusPend,
  output logic               rpsInt,
  output logic               cmdCmpl
);

  slvStrobe_t stb;
  logic       rpsEn;

  slvint_ctrl #(.TGT_W(TGT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .slaveReset(slaveReset), .excSet(excSet),
    .statusReadDone(statusReadDone), .masterOk(masterOk),
    .rpsTargetLoad(rpsTargetLoad), .rpsTargetVal(rpsTargetVal),
    .rpsOnTarget(rpsOnTarget), .dataCtlAccept(dataCtlAccept),
    .busCtlAccept(busCtlAccept), .cmdDone(cmdDone), .cmdTimeDep(cmdTimeDep),
    .cmdIsLoadPos(cmdIsLoadPos), .busy(busy), .rpsEn(rpsEn), .stb(stb)
  );

  slvint_core core_i (
    .clk(clk), .rstN(rstN), .stb(stb), .statusPend(statusPend),
    .rpsInt(rpsInt), .cmdCmpl(cmdCmpl), .rpsEn(rpsEn)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    slvint_port port_i (
      .clk(clk), .rstN(rstN), .stb(stb), .prioSeen(prioSeen[p]),
      .reportReq(reportReq[p]), .seqEnd(seqEnd[p]), .selected(selected[p]),
      .selAttempt(selAttempt[p]), .enWr(enWr[p]), .enData(enData),
      .busy(busy), .ready(ready), .statusPend(statusPend), .rpsInt(rpsInt),
      .cmdCmpl(cmdCmpl), .octet(intOctet[8*p +: 8]), .attn(attn[p])
    );
  end

endmodule

// File: rtl/slave_attn_ctrl_chk.sv
module slave_attn_ctrl_chk #(
  parameter int PORTS = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               slaveReset,
  input logic               excSet,
  input logic               statusReadDone,
  input logic               masterOk,
  input logic               rpsOnTarget,
  input logic               busCtlAccept,
  input logic               cmdDone,
  input logic [PORTS-1:0]   selected,
  input logic [PORTS-1:0]   attn,
  input logic [8*PORTS-1:0] intOctet,
  input logic               statusPend,
  input logic               rpsInt,
  input logic               cmdCmpl
);

  a_r1_status_clears: assert property (@(posedge clk) disable iff (!rstN)
    statusPend && statusReadDone && masterOk && !excSet |=> !statusPend);

  a_r2_status_kept: assert property (@(posedge clk) disable iff (!rstN)
    statusPend && statusReadDone && !masterOk && !slaveReset |=> statusPend);

  a_r3_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    slaveReset |=> !statusPend && !rpsInt && !cmdCmpl);

  a_r4_rps_off_target: assert property (@(posedge clk) disable iff (!rstN)
    !rpsOnTarget |=> !rpsInt);

  a_r6_cmd_cleared: assert property (@(posedge clk) disable iff (!rstN)
    busCtlAccept && !cmdDone |=> !cmdCmpl);

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    a_r7_octet_layout: assert property (@(posedge clk) disable iff (!rstN)
      !intOctet[8*p+7] && !intOctet[8*p+4] && intOctet[8*p+2] == statusPend
      && intOctet[8*p+1] == rpsInt && intOctet[8*p] == cmdCmpl);

    a_r9_quiet_when_selected: assert property (@(posedge clk) disable iff (!rstN)
      selected[p] |-> !attn[p]);
  end

endmodule

bind slave_attn_ctrl slave_attn_ctrl_chk #(.PORTS(PORTS)) chk_i (
  .clk(clk), .rstN(rstN), .slaveReset(slaveReset), .excSet(excSet),
  .statusReadDone(statusReadDone), .masterOk(masterOk),
  .rpsOnTarget(rpsOnTarget), .busCtlAccept(busCtlAccept), .cmdDone(cmdDone),
  .selected(selected), .attn(attn), .intOctet(intOctet),
  .statusPend(statusPend), .rpsInt(rpsInt), .cmdCmpl(cmdCmpl)
);

// File: tb/slave_attn_ctrl_tb_top.sv
module slave_attn_ctrl_tb_top;

  localparam int PORTS = 2;
  localparam int TGT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveReset = 0, excSet = 0, statusReadDone = 0, masterOk = 0;
  logic rpsTargetLoad = 0, rpsOnTarget = 0;
  logic [TGT_W-1:0] rpsTargetVal = '0;
  logic busCtlAccept = 0, dataCtlAccept = 0, cmdDone = 0, cmdTimeDep = 0;
  logic cmdIsLoadPos = 0, busy = 0, ready = 0;
  logic [PORTS-1:0] prioSeen = '0, reportReq = '0, seqEnd = '0;
  logic [PORTS-1:0] selected = '0, selAttempt = '0, enWr = '0;
  logic [3:0] enData = '0;
  logic [8*PORTS-1:0] intOctet;
  logic [PORTS-1:0] attn;
  logic statusPend, rpsInt, cmdCmpl;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  slave_attn_ctrl #(.PORTS(PORTS), .TGT_W(TGT_W)) dut_i (.*);

  // {busy, ready, expected port-0 octet} with all flags clear
  localparam logic [9:0] OCT_VEC [4] = '{
    10'b00_00000000, 10'b01_00100000, 10'b10_01000000, 10'b11_01100000
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R3 R7: reset state
    check("R3 reset octets", intOctet, 16'h0000);
    check("R3 reset attn", {14'd0, attn}, 16'd0);
    check("R3 reset flags", {13'd0, statusPend, rpsInt, cmdCmpl}, 16'd0);

    // R7: busy/ready positions
    for (int i = 0; i < 4; i++) begin
      busy = OCT_VEC[i][9]; ready = OCT_VEC[i][8];
      tick(); tick();
      check("R7 octet busy/ready", {8'd0, intOctet[7:0]}, {8'd0, OCT_VEC[i][7:0]});
    end
    busy = 0; ready = 0;
    tick(); tick();
    selAttempt = 2'b11; tick(); selAttempt = 0; tick();

    // R1 R9: status exception
    excSet = 1; tick(); excSet = 0;
    check("R1 status set", {8'd0, intOctet[7:0]}, 16'h0004);
    check("R9 attn unselected", {14'd0, attn}, 16'd3);
    selected = 2'b01; tick();
    check("R9 attn selected port", {14'd0, attn}, 16'd2);
    selected = 0;
    statusReadDone = 1; masterOk = 0; tick(); statusReadDone = 0;
    check("R2 status kept on failed read", {15'd0, statusPend}, 16'd1);
    statusReadDone = 1; masterOk = 1; tick(); statusReadDone = 0; masterOk = 0;
    check("R1 status cleared", {15'd0, statusPend}, 16'd0);

    // R4: before a target is loaded nothing happens
    rpsOnTarget = 1; tick(); tick();
    check("R4 no target after reset", {15'd0, rpsInt}, 16'd0);
    rpsOnTarget = 0; tick();
    rpsTargetLoad = 1; rpsTargetVal = 16'h0010; tick(); rpsTargetLoad = 0;
    rpsOnTarget = 1; tick();
    check("R4 rps on target", {8'd0, intOctet[15:8]}, 16'h0002);
    rpsOnTarget = 0; tick();
    check("R4 rps off target", {15'd0, rpsInt}, 16'd0);

    // R5: data control drops it while still on target
    rpsOnTarget = 1; tick();
    busCtlAccept = 1; dataCtlAccept = 1; tick(); busCtlAccept = 0; dataCtlAccept = 0;
    check("R5 dropped by data control", {15'd0, rpsInt}, 16'd0);
    tick();
    check("R5 stays dropped", {15'd0, rpsInt}, 16'd0);
    rpsOnTarget = 0; tick(); rpsOnTarget = 1; tick();
    check("R5 back on next arrival", {15'd0, rpsInt}, 16'd1);
    rpsOnTarget = 0; tick();

    // R6: command completion
    cmdDone = 1; cmdTimeDep = 1; cmdIsLoadPos = 1; tick(); cmdDone = 0;
    check("R6 load-position with target enabled", {15'd0, cmdCmpl}, 16'd0);
    cmdDone = 1; cmdIsLoadPos = 0; tick(); cmdDone = 0;
    check("R6 completion set", {8'd0, intOctet[7:0]}, 16'h0001);
    busCtlAccept = 1; tick(); busCtlAccept = 0;
    check("R6 cleared by bus control", {15'd0, cmdCmpl}, 16'd0);
    cmdDone = 1; cmdTimeDep = 0; tick(); cmdDone = 0;
    check("R6 not time-dependent", {15'd0, cmdCmpl}, 16'd0);

    // R4: all-ones target disables
    rpsTargetLoad = 1; rpsTargetVal = 16'hFFFF; tick(); rpsTargetLoad = 0;
    rpsOnTarget = 1; tick();
    check("R4 disabled target", {15'd0, rpsInt}, 16'd0);
    rpsOnTarget = 0;
    cmdDone = 1; cmdTimeDep = 1; cmdIsLoadPos = 1; tick(); cmdDone = 0; cmdIsLoadPos = 0;
    check("R6 load-position with target off", {15'd0, cmdCmpl}, 16'd1);
    busCtlAccept = 1; tick(); busCtlAccept = 0;

    // R8: priority notice
    prioSeen = 2'b10; tick(); prioSeen = 0;
    check("R8 notice on port 1", {intOctet[11], intOctet[3]}, 16'd2);
    seqEnd = 2'b10; tick(); seqEnd = 0;
    check("R8 kept when unreported", {15'd0, intOctet[11]}, 16'd1);
    reportReq = 2'b10; tick(); reportReq = 0;
    seqEnd = 2'b10; tick(); seqEnd = 0;
    check("R8 cleared after report", {15'd0, intOctet[11]}, 16'd0);

    // R10 R11: no-longer-busy
    enWr = 2'b01; enData = 4'b1000; tick(); enWr = 0;
    busy = 1; tick(); busy = 0; tick(); tick();
    check("R10 attn after busy fell", {14'd0, attn}, 16'd1);
    selAttempt = 2'b01; tick(); selAttempt = 0;
    check("R10 cleared by selection attempt", {14'd0, attn}, 16'd0);

    // R11: port 0 masked, port 1 unchanged
    enWr = 2'b01; enData = 4'b0000; tick(); enWr = 0;
    excSet = 1; tick(); excSet = 0;
    check("R11 per-port enables", {14'd0, attn}, 16'd2);

    // R3: slave reset
    cmdDone = 1; cmdTimeDep = 1; prioSeen = 2'b01; tick(); cmdDone = 0; prioSeen = 0;
    slaveReset = 1; tick(); slaveReset = 0;
    check("R3 slave reset octets", intOctet, 16'h0000);
    excSet = 1; tick(); excSet = 0;
    check("R3 enables restored", {14'd0, attn}, 16'd3);
    busy = 1; tick(); busy = 0; tick(); tick();
    selAttempt = 2'b00;
    statusReadDone = 1; masterOk = 1; tick(); statusReadDone = 0; masterOk = 0;
    check("R10 nb enable off after reset", {14'd0, attn}, 16'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule